// File: doc/BRIEF.md
# Fractional Slot Baud Rate Generator

This block turns a fast reference clock into the 16x oversampling tick that a UART serializer and receiver consume. A bit period is split into sixteen slots. Every slot lasts a whole number of reference clocks given by a divisor register. A 16-bit slot mask can stretch any slot by a single extra clock, so the bit period can be tuned in steps of one reference clock rather than sixteen. Software sets the divisor to the integer part of (reference clock / baud) / 16, minus one. It then picks a mask whose number of set bits equals the remainder of (reference clock / baud) modulo 16. The set bits should be spread across the bit, not packed together, so the sample points stay evenly spaced.

The block emits a one-clock tick at the end of each slot, and a bit-boundary strobe together with the tick that closes the last slot. The divisor and mask inputs are copied into working registers only at a bit boundary, or at any time while the generator is disabled. A write in the middle of a bit therefore never distorts the bit in flight. Dropping the enable clears the counters, and the next bit starts from slot 0.

Top module: `frac_baud_gen`

## Requirements
- R1: While the synchronous active-high reset is asserted, `tick_o` and `bit_strobe_o` are low, and the slot position returns to slot 0.
- R2: Every bit period holds exactly 16 ticks. `bit_strobe_o` is high only in the same cycle as a tick, and only on the sixteenth tick, which closes slot 15.
- R3: Slot i (slot 0 is the first slot after a bit boundary) lasts `div_i + 1` reference clocks, plus one more when bit i of the slot mask is set. Bit 0 is the least significant mask bit.
- R4: The spacing between two consecutive bit strobes is 16 x (divisor + 1) + (number of set bits in the mask) reference clocks. This holds for the spread masks 0x0000, 0x0080, 0x0808, 0x0888, 0x2222, 0x4924, 0x4A52, 0x54AA, 0x5555, 0xDDDD, 0xDFDF and 0xFFDF.
- R5: A divisor of 0 gives slots of one reference clock, plus any extension from the mask. Mask 0x0000 then gives a 16-clock bit, and mask 0xFFFF gives a 32-clock bit.
- R6: Divisor and mask values that change inside a bit do not affect that bit. They take effect from the next bit boundary.
- R7: From the first cycle after `enable` is sampled low, no tick or strobe appears. When `enable` rises again, the first bit starts fresh from slot 0 with the values then present on the inputs. Its strobe comes exactly one full bit length (R4) of clocks after the first enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the generator; low clears the counters |
| div_i | input | DIV_W (16) | Reference clocks per slot, minus one |
| slot_mask_i | input | SLOTS (16) | Per-slot one-clock extension mask |
| tick_o | output | 1 | Pulses at the end of each slot |
| bit_strobe_o | output | 1 | Pulses with the tick that ends slot 15 |

## Verification
The assertions rely on `enable` and the configuration inputs being steady around each rising edge. They also rely on the working configuration changing only through the boundary load, so the cycle count between strobes can be compared against a total taken from the registers loaded at the previous strobe. The stimulus changes every input one nanosecond after a falling edge and never during reset release. It keeps divisors small enough that each run stays short, with one large divisor included to exercise the wide counter. Mid-bit writes are placed a few cycles after a strobe, so the boundary load is known to see the new values only at the following strobe.

// File: rtl/frac_baud_gen_pkg.sv
package frac_baud_gen_pkg;

    localparam int unsigned SLOTS_DEF = 16;
    localparam int unsigned DIV_W_DEF = 16;

    // Number of set bits in a mask of up to 64 bits.
    function automatic int unsigned mask_ones(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // Clocks in one bit: slots * (div + 1) + extensions.
    function automatic int unsigned bit_clocks(input int unsigned slots,
                                               input int unsigned div,
                                               input logic [63:0] mask);
        return slots * (div + 1) + mask_ones(mask);
    endfunction

    // Generator phase, used for readability of the top-level control.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SLOT  = 2'd1,
        PH_BOUND = 2'd2
    } gen_phase_e;

endpackage

// File: rtl/bgen_cfg_shadow.sv
module bgen_cfg_shadow #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [SLOTS-1:0] mask_in,
    output logic [DIV_W-1:0] div_q,
    output logic [SLOTS-1:0] mask_q
);
    // Working copy of the rate setting; only replaced when load is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            div_q  <= div_in;
            mask_q <= mask_in;
        end
    end
endmodule

// File: rtl/bgen_tick_timer.sv
module bgen_tick_timer #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] term,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Slot ends when the count reaches the terminal value.
    assign done = run && (cnt_q == term);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bgen_slot_seq.sv
module bgen_slot_seq #(
    parameter int unsigned SLOTS = 16,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] idx_q;

    assign idx  = idx_q;
    assign last = (idx_q == IDX_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= last ? '0 : idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_gen_pkg::*;
#(
    parameter int unsigned DIV_W = DIV_W_DEF,
    parameter int unsigned SLOTS = SLOTS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    input  logic [SLOTS-1:0] slot_mask_i,
    output logic             tick_o,
    output logic             bit_strobe_o
);
    localparam int unsigned CNT_W = DIV_W + 1;
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [DIV_W-1:0] act_div;
    logic [SLOTS-1:0] act_mask;
    logic [IDX_W-1:0] slot_idx;
    logic             slot_last;
    logic             slot_done;
    logic             stretch;
    logic [CNT_W-1:0] slot_term;
    logic             bound;
    logic             cfg_load;
    gen_phase_e       phase;
    logic             tick_q;
    logic             strobe_q;

    // Phase decode of the current cycle.
    always_comb begin
        if (!enable)                     phase = PH_IDLE;
        else if (slot_done && slot_last) phase = PH_BOUND;
        else                             phase = PH_SLOT;
    end

    assign bound    = (phase == PH_BOUND);
    assign cfg_load = (phase == PH_IDLE) || bound;

    bgen_cfg_shadow #(.DIV_W(DIV_W), .SLOTS(SLOTS)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .div_in  (div_i),
        .mask_in (slot_mask_i),
        .div_q   (act_div),
        .mask_q  (act_mask)
    );

    // Extension bit for the slot in progress.
    assign stretch   = act_mask[slot_idx];
    assign slot_term = {1'b0, act_div} + CNT_W'(stretch);

    bgen_tick_timer #(.CNT_W(CNT_W)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .term (slot_term),
        .done (slot_done)
    );

    bgen_slot_seq #(.SLOTS(SLOTS)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .run     (enable),
        .advance (slot_done),
        .idx     (slot_idx),
        .last    (slot_last)
    );

    // Registered pulse outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            tick_q   <= slot_done;
            strobe_q <= bound;
        end
    end

    assign tick_o       = tick_q;
    assign bit_strobe_o = strobe_q;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk
    import frac_baud_gen_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned SLOTS = 16,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             tick_o,
    input logic             bit_strobe_o,
    input logic [DIV_W-1:0] act_div,
    input logic [SLOTS-1:0] act_mask,
    input logic [IDX_W-1:0] slot_idx
);
    logic        seen_q;
    int unsigned run_q;
    int unsigned exp_q;
    int unsigned ticks_q;

    // Observation counters between strobes.
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seen_q  <= 1'b0;
            run_q   <= 0;
            exp_q   <= 0;
            ticks_q <= 0;
        end else if (bit_strobe_o) begin
            seen_q  <= 1'b1;
            run_q   <= 1;
            exp_q   <= bit_clocks(SLOTS, int'(act_div), 64'(act_mask));
            ticks_q <= 0;
        end else begin
            run_q   <= run_q + 1;
            if (tick_o) ticks_q <= ticks_q + 1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tick_o && !bit_strobe_o));

    assert_strobe_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        bit_strobe_o |-> tick_o);

    assert_sixteen_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && bit_strobe_o) |-> (ticks_q == SLOTS - 1));

    assert_slot_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        enable |=> ($stable(slot_idx) || tick_o));

    assert_bit_length_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && bit_strobe_o) |-> (run_q == exp_q));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        enable |=> (($stable(act_div) && $stable(act_mask)) || bit_strobe_o));

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!tick_o && !bit_strobe_o));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W), .SLOTS(SLOTS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .tick_o       (tick_o),
    .bit_strobe_o (bit_strobe_o),
    .act_div      (act_div),
    .act_mask     (act_mask),
    .slot_idx     (slot_idx)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;

    typedef struct {
        int unsigned div;
        logic [15:0] mask;
    } bit_cfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] div_i = '0;
    logic [15:0] slot_mask_i = '0;
    logic        tick_o;
    logic        bit_strobe_o;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done = 1'b0;
    bit_cfg_t    expq[$];

    always #10 clk = ~clk;

    frac_baud_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .div_i        (div_i),
        .slot_mask_i  (slot_mask_i),
        .tick_o       (tick_o),
        .bit_strobe_o (bit_strobe_o)
    );

    function automatic int unsigned ones16(input logic [15:0] m);
        int unsigned n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int unsigned total_of(input int unsigned d, input logic [15:0] m);
        return 16 * (d + 1) + ones16(m);
    endfunction

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected configuration per tracked bit.
    bit          cur_valid = 1'b0;
    bit_cfg_t    cur;
    int unsigned cyc = 0, tcyc = 0, ticks = 0, slot = 0;

    always @(negedge clk) begin
        if (rst || !enable) begin
            cur_valid = 1'b0;
        end else begin
            cyc++;
            tcyc++;
            if (bit_strobe_o && !tick_o)
                check(1'b0, "R2 strobe without tick", 0, 1);
            if (tick_o) begin
                if (cur_valid && slot < 16)
                    check(tcyc == cur.div + 1 + int'(cur.mask[slot]), "R3 slot length",
                          tcyc, cur.div + 1 + int'(cur.mask[slot]));
                slot++;
                ticks++;
                tcyc = 0;
            end
            if (bit_strobe_o) begin
                if (cur_valid) begin
                    check(cyc == total_of(cur.div, cur.mask), "R4 bit length",
                          cyc, total_of(cur.div, cur.mask));
                    check(ticks == 16, "R2 ticks per bit", ticks, 16);
                end
                if (expq.size() > 0) begin
                    cur = expq.pop_front();
                    cur_valid = 1'b1;
                end else begin
                    cur_valid = 1'b0;
                end
                cyc = 0; tcyc = 0; ticks = 0; slot = 0;
            end
        end
    end

    task automatic wait_strobes(input int unsigned n);
        int unsigned seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (bit_strobe_o) seen++;
        end
    endtask

    // Driver: runs nbits tracked bits with one configuration.
    task automatic run_bits(input int unsigned d, input logic [15:0] m, input int unsigned nbits);
        @(negedge clk); #1;
        div_i = 16'(d);
        slot_mask_i = m;
        for (int i = 0; i < int'(nbits); i++) expq.push_back('{div: d, mask: m});
        enable = 1'b1;
        wait_strobes(nbits + 1);
        #1 enable = 1'b0;
    endtask

    // Strobe distance from the enabling edge for a fresh start.
    task automatic first_bit(input int unsigned d, input logic [15:0] m, input string req);
        int unsigned k = 0;
        @(negedge clk); #1;
        div_i = 16'(d);
        slot_mask_i = m;
        @(negedge clk); #1;
        enable = 1'b1;
        do begin
            @(negedge clk);
            k++;
        end while (!bit_strobe_o && k < 200000);
        check(k == total_of(d, m), req, k, total_of(d, m));
        #1 enable = 1'b0;
    endtask

    initial begin
        // R1: reset keeps the outputs quiet even with enable high.
        div_i = 16'd0;
        enable = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!tick_o && !bit_strobe_o, "R1 reset quiet", {tick_o, bit_strobe_o}, 0);
        end
        #1 enable = 1'b0;
        @(negedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!tick_o && !bit_strobe_o, "R1 after reset idle", {tick_o, bit_strobe_o}, 0);

        // R4: recommended spread masks, R3 per slot, R2 tick count.
        run_bits(2, 16'h0000, 2);
        run_bits(0, 16'h0080, 2);
        run_bits(1, 16'h0808, 2);
        run_bits(3, 16'h0888, 2);
        run_bits(0, 16'h2222, 2);
        run_bits(2, 16'h4924, 2);
        run_bits(1, 16'h4A52, 2);
        run_bits(0, 16'h54AA, 2);
        run_bits(1, 16'h5555, 2);
        run_bits(2, 16'hDDDD, 2);
        run_bits(0, 16'hDFDF, 2);
        run_bits(1, 16'hFFDF, 2);
        run_bits(300, 16'h8000, 2);

        // R5: zero divisor.
        first_bit(0, 16'h0000, "R5 div0 no stretch");
        first_bit(0, 16'hFFFF, "R5 div0 all stretched");
        run_bits(0, 16'h0000, 2);

        // R6: mid-bit change takes effect at the next boundary.
        @(negedge clk); #1;
        div_i = 16'd1;
        slot_mask_i = 16'h0000;
        expq.push_back('{div: 1, mask: 16'h0000});
        expq.push_back('{div: 3, mask: 16'h5555});
        expq.push_back('{div: 3, mask: 16'h5555});
        enable = 1'b1;
        wait_strobes(1);
        repeat (3) @(negedge clk);
        #1;
        div_i = 16'd3;
        slot_mask_i = 16'h5555;
        wait_strobes(3);
        #1 enable = 1'b0;
        @(negedge clk);
        check(expq.size() == 0, "R6 queued bits consumed", expq.size(), 0);

        // R7: disable mid-bit silences outputs, then a fresh full bit.
        @(negedge clk); #1;
        div_i = 16'd4;
        slot_mask_i = 16'h0101;
        enable = 1'b1;
        repeat (30) @(negedge clk);
        #1 enable = 1'b0;
        begin
            int unsigned hits = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (tick_o || bit_strobe_o) hits++;
            end
            check(hits == 0, "R7 quiet while disabled", hits, 0);
        end
        first_bit(4, 16'h0101, "R7 fresh bit after re-enable");
        first_bit(7, 16'h0888, "R7 fresh bit new values");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule